// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Framer

This block serialises one 193-bit T1-style frame at a time. Each frame is one framing bit followed by 24 channel slots of 8 bits. The host presents 24 parallel 8-bit channel samples and a 4-bit signaling nibble per channel. The block captures them when it starts a frame and then shifts the frame out one bit per cycle in which the bit-clock enable is high. At 1.544 Mbps this is 8000 frames per second.

The block counts frames inside a 24-frame superframe. In the sixth, twelfth, eighteenth and twenty-fourth frame it overwrites the last bit of every slot (the sample LSB) with one signaling bit: the first of these frames carries the A bit, the second B, the third C and the fourth D. A clear-channel input turns this off, so every sample passes through with all 8 bits intact. The framing bit comes from a per-frame placeholder pattern parameter. The output carries markers for the start of each frame and the start of the superframe.

The control is a two-state sequencer. `ST_FBIT` sends the framing bit and captures the inputs. It always moves on to `ST_SLOT` after one enabled bit. `ST_SLOT` sends slot bits. It stays in `ST_SLOT` until the last bit of slot 23, then returns to `ST_FBIT` and the frame index advances, wrapping from 23 to 0.

Top module: `t1_sig_framer`

## Requirements
- R1: A synchronous reset drives `ser_out`, `frm_start` and `sf_start` low. It places the sequencer at the framing bit of frame index 0, so the next enabled bit is that frame's framing bit, marked by `sf_start`.
- R2: Each frame is 193 enabled bits: the framing bit, then slots 0 to 23 in order. Slot s carries `smp_data[8s+7:8s]` with the MSB sent first.
- R3: The framing bit of frame index k (0 to 23) is bit k of parameter `FBIT_PAT`. `frm_start` is high exactly while a framing bit is on `ser_out`. `sf_start` is high only on the framing bit of frame index 0, and frame indices repeat every 24 frames.
- R4: In frames whose index k satisfies k mod 6 != 5, all 8 bits of every slot are the captured sample unchanged.
- R5: In frame indices 5, 11, 17 and 23, with clear-channel off, the last (eighth) bit of every slot s is replaced by a signaling bit. The bit is A, B, C or D respectively. The nibble layout is A = `sig_nib[4s+3]`, B = `sig_nib[4s+2]`, C = `sig_nib[4s+1]`, D = `sig_nib[4s]`.
- R6: `clear_mode` is captured with the samples at frame start. When the captured value is 1, no bit of that frame is replaced. A change of `clear_mode` mid-frame has no effect on the frame in progress.
- R7: `smp_data`, `sig_nib` and `clear_mode` are captured on the cycle `ld_take` is high. Changes after that do not alter the frame being sent.
- R8: While `bit_en` is low, the position does not advance and `ser_out`, `frm_start` and `sf_start` keep their values.
- R9: `ld_take` is high exactly when `bit_en` is high and the sequencer is at a framing bit. Output bits appear on `ser_out` one cycle after the enabled cycle that selects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable, one line bit per enabled cycle |
| clear_mode | input | 1 | 1 = clear channel, no signaling bits inserted |
| smp_data | input | 192 | Channel samples, slot s in bits [8s+7:8s] |
| sig_nib | input | 96 | Signaling nibbles, slot s in bits [4s+3:4s] (A is the MSB) |
| ld_take | output | 1 | Inputs are captured at the end of this cycle |
| ser_out | output | 1 | Serial line bit |
| frm_start | output | 1 | High during each framing bit |
| sf_start | output | 1 | High during the framing bit of frame index 0 |

## Verification
The hardest cases to reach are the D-bit frame at the end of the superframe and a change to `clear_mode` or the samples after capture within a signaling frame. Each of these lies thousands of enabled bits from reset. The stimulus therefore runs whole superframes back to back. It gives every frame a different sample and nibble pattern, so a wrongly chosen letter or slot shows up as a wrong bit. Some frames rewrite all inputs, including `clear_mode`, partway through. Others insert idle cycles with `bit_en` low at many bit positions, including slot boundaries and the robbed bit. A reset in the middle of a frame checks that the superframe restarts at frame index 0.

// File: rtl/t1f_pkg.sv
package t1f_pkg;
    typedef enum logic [0:0] {
        ST_FBIT = 1'b0,
        ST_SLOT = 1'b1
    } pos_st_t;
endpackage

// File: rtl/t1f_seq.sv
module t1f_seq
    import t1f_pkg::*;
#(
    parameter int NCH = 24,
    parameter int SW  = 8,
    parameter int NFR = 24,
    localparam int FW = $clog2(NFR),
    localparam int CW = $clog2(NCH),
    localparam int BW = $clog2(SW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output pos_st_t       st,
    output logic [FW-1:0] fr,
    output logic [CW-1:0] slot,
    output logic [BW-1:0] bidx
);
    pos_st_t st_q, st_d;
    logic    slot_last, bit_last;

    assign bit_last  = (bidx == BW'(SW - 1));
    assign slot_last = (slot == CW'(NCH - 1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_FBIT;
        else if (en) st_q <= st_d;
    end

    // next state
    always_comb begin
        unique case (st_q)
            ST_FBIT: st_d = ST_SLOT;
            ST_SLOT: st_d = (slot_last && bit_last) ? ST_FBIT : ST_SLOT;
            default: st_d = ST_FBIT;
        endcase
    end

    // position counters
    always_ff @(posedge clk) begin
        if (rst) begin
            fr   <= '0;
            slot <= '0;
            bidx <= '0;
        end else if (en && st_q == ST_SLOT) begin
            if (bit_last) begin
                bidx <= '0;
                if (slot_last) begin
                    slot <= '0;
                    fr   <= (fr == FW'(NFR - 1)) ? '0 : fr + 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else begin
                bidx <= bidx + 1'b1;
            end
        end
    end

    assign st = st_q;
endmodule

// File: rtl/t1f_hold.sv
module t1f_hold #(
    parameter int NCH  = 24,
    parameter int SW   = 8,
    parameter int NSIG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap,
    input  logic [NCH*SW-1:0]   smp_i,
    input  logic [NCH*NSIG-1:0] sig_i,
    input  logic                clr_i,
    output logic [NCH*SW-1:0]   smp_q,
    output logic [NCH*NSIG-1:0] sig_q,
    output logic                clr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            sig_q <= '0;
            clr_q <= 1'b0;
        end else if (cap) begin
            smp_q <= smp_i;
            sig_q <= sig_i;
            clr_q <= clr_i;
        end
    end
endmodule

// File: rtl/t1f_pick.sv
module t1f_pick
    import t1f_pkg::*;
#(
    parameter int          NCH      = 24,
    parameter int          SW       = 8,
    parameter int          NFR      = 24,
    parameter int          ROB      = 6,
    parameter logic [23:0] FBIT_PAT = 24'h9A3C5E,
    localparam int NSIG = NFR / ROB,
    localparam int FW   = $clog2(NFR),
    localparam int CW   = $clog2(NCH),
    localparam int BW   = $clog2(SW)
) (
    input  pos_st_t             st,
    input  logic [FW-1:0]       fr,
    input  logic [CW-1:0]       slot,
    input  logic [BW-1:0]       bidx,
    input  logic [NCH*SW-1:0]   smp,
    input  logic [NCH*NSIG-1:0] sig,
    input  logic                clr,
    output logic                bit_o
);
    logic [SW-1:0] byte_v;
    logic          rob;
    int            s_i, b_i, f_i, let_i;

    always_comb begin
        s_i    = int'(slot);
        b_i    = int'(bidx);
        f_i    = int'(fr);
        let_i  = f_i / ROB;
        byte_v = smp[s_i*SW +: SW];
        rob    = !clr && (f_i % ROB == ROB - 1) && (b_i == SW - 1);
        if (st == ST_FBIT)
            bit_o = FBIT_PAT[f_i];
        else if (rob)
            bit_o = sig[s_i*NSIG + (NSIG - 1 - let_i)];
        else
            bit_o = byte_v[SW - 1 - b_i];
    end
endmodule

// File: rtl/t1_sig_framer.sv
module t1_sig_framer
    import t1f_pkg::*;
#(
    parameter int          NCH      = 24,
    parameter int          SW       = 8,
    parameter int          NFR      = 24,
    parameter int          ROB      = 6,
    parameter logic [23:0] FBIT_PAT = 24'h9A3C5E,
    localparam int NSIG = NFR / ROB,
    localparam int FW   = $clog2(NFR),
    localparam int CW   = $clog2(NCH),
    localparam int BW   = $clog2(SW)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                clear_mode,
    input  logic [NCH*SW-1:0]   smp_data,
    input  logic [NCH*NSIG-1:0] sig_nib,
    output logic                ld_take,
    output logic                ser_out,
    output logic                frm_start,
    output logic                sf_start
);
    pos_st_t             st;
    logic [FW-1:0]       fr;
    logic [CW-1:0]       slot;
    logic [BW-1:0]       bidx;
    logic [NCH*SW-1:0]   smp_q;
    logic [NCH*NSIG-1:0] sig_q;
    logic                clr_q;
    logic                nxt_bit;

    t1f_seq #(.NCH(NCH), .SW(SW), .NFR(NFR)) u_seq (
        .clk(clk), .rst(rst), .en(bit_en),
        .st(st), .fr(fr), .slot(slot), .bidx(bidx)
    );

    assign ld_take = bit_en && (st == ST_FBIT);

    t1f_hold #(.NCH(NCH), .SW(SW), .NSIG(NSIG)) u_hold (
        .clk(clk), .rst(rst), .cap(ld_take),
        .smp_i(smp_data), .sig_i(sig_nib), .clr_i(clear_mode),
        .smp_q(smp_q), .sig_q(sig_q), .clr_q(clr_q)
    );

    t1f_pick #(.NCH(NCH), .SW(SW), .NFR(NFR), .ROB(ROB), .FBIT_PAT(FBIT_PAT)) u_pick (
        .st(st), .fr(fr), .slot(slot), .bidx(bidx),
        .smp(smp_q), .sig(sig_q), .clr(clr_q), .bit_o(nxt_bit)
    );

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out   <= 1'b0;
            frm_start <= 1'b0;
            sf_start  <= 1'b0;
        end else if (bit_en) begin
            ser_out   <= nxt_bit;
            frm_start <= (st == ST_FBIT);
            sf_start  <= (st == ST_FBIT) && (fr == '0);
        end
    end
endmodule

// File: rtl/t1f_chk.sv
module t1f_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic ld_take,
    input logic ser_out,
    input logic frm_start,
    input logic sf_start
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ser_out && !frm_start && !sf_start));

    // R3
    sf_in_frm_chk: assert property (@(posedge clk) disable iff (rst)
        sf_start |-> frm_start);

    // R3
    frm_single_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_start && bit_en) |=> !frm_start);

    // R9
    take_marks_chk: assert property (@(posedge clk) disable iff (rst)
        ld_take |=> frm_start);

    // R9
    take_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        ld_take |-> bit_en);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(ser_out) && $stable(frm_start) && $stable(sf_start)));
endmodule

bind t1_sig_framer t1f_chk u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ld_take(ld_take),
    .ser_out(ser_out), .frm_start(frm_start), .sf_start(sf_start)
);

// File: tb/t1_sig_framer_bench.sv
module t1_sig_framer_bench;
    localparam logic [23:0] PAT = 24'h9A3C5E;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bit_en = 1'b0;
    logic         clear_mode = 1'b0;
    logic [191:0] smp_data = '0;
    logic [95:0]  sig_nib = '0;
    logic         ld_take, ser_out, frm_start, sf_start;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // bench model of line position and captured inputs
    int           m_fr = 0;
    int           m_pos = 0;
    logic [191:0] m_dat = '0;
    logic [95:0]  m_sig = '0;
    logic         m_clr = 1'b0;

    t1_sig_framer #(.FBIT_PAT(PAT)) u_t1_sig_framer (
        .clk(clk), .rst(rst), .bit_en(bit_en), .clear_mode(clear_mode),
        .smp_data(smp_data), .sig_nib(sig_nib), .ld_take(ld_take),
        .ser_out(ser_out), .frm_start(frm_start), .sf_start(sf_start)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s fr=%0d pos=%0d: actual %0d expected %0d", tag, m_fr, m_pos, act, exp);
        end
    endtask

    task automatic set_inputs(input int seed);
        for (int c = 0; c < 24; c++) begin
            smp_data[c*8 +: 8] = 8'((c * 29 + seed * 13 + 7) % 256);
            sig_nib[c*4 +: 4]  = 4'((c * 5 + seed * 3 + 1) % 16);
        end
    endtask

    function automatic logic exp_bit(output string tag);
        int p, s, b, let_i;
        logic [7:0] byt;
        if (m_pos == 0) begin
            tag = "R3";
            return PAT[m_fr];
        end
        p = m_pos - 1;
        s = p / 8;
        b = p % 8;
        byt = m_dat[s*8 +: 8];
        if (m_fr % 6 != 5) begin
            tag = "R4";
            return byt[7-b];
        end
        if (b == 7) begin
            let_i = m_fr / 6;
            if (m_clr) begin
                tag = "R6";
                return byt[0];
            end
            tag = "R5";
            return m_sig[s*4 + 3 - let_i];
        end
        tag = "R2";
        return byt[7-b];
    endfunction

    // called at a falling edge; drives bit_en, takes one clock, checks
    task automatic tick(input logic en);
        logic  p_ser, p_frm, p_sf, eb;
        string tg;
        bit_en = en;
        #0;
        chk(ld_take === (en && m_pos == 0), "R9 ld_take", int'(ld_take), int'(en && m_pos == 0));
        if (en && m_pos == 0) begin
            m_dat = smp_data;  // R7 capture point
            m_sig = sig_nib;
            m_clr = clear_mode;
        end
        p_ser = ser_out; p_frm = frm_start; p_sf = sf_start;
        @(posedge clk);
        @(negedge clk);
        if (en) begin
            eb = exp_bit(tg);
            chk(ser_out === eb, tg, int'(ser_out), int'(eb));
            chk(frm_start === (m_pos == 0), "R3 frm_start", int'(frm_start), int'(m_pos == 0));
            chk(sf_start === (m_pos == 0 && m_fr == 0), "R3 sf_start", int'(sf_start),
                int'(m_pos == 0 && m_fr == 0));
            m_pos++;
            if (m_pos == 193) begin
                m_pos = 0;
                m_fr = (m_fr + 1) % 24;
            end
        end else begin
            chk(ser_out === p_ser && frm_start === p_frm && sf_start === p_sf,
                "R8 hold", int'({ser_out, frm_start, sf_start}), int'({p_ser, p_frm, p_sf}));
        end
    endtask

    task automatic run_frame(input int seed, input bit mid, input bit gaps, input bit clr);
        set_inputs(seed);
        clear_mode = clr;
        for (int b = 0; b < 193; b++) begin
            if (mid && b == 120) begin  // R7 R6 late changes
                set_inputs(seed + 50);
                clear_mode = !clr;
            end
            if (gaps && (b % 7) == 3) begin
                tick(1'b0);
                tick(1'b0);
            end
            tick(1'b1);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_fr = 0;
        m_pos = 0;
        // R1
        chk(ser_out === 1'b0, "R1 ser_out", int'(ser_out), 0);
        chk(frm_start === 1'b0, "R1 frm_start", int'(frm_start), 0);
        chk(sf_start === 1'b0, "R1 sf_start", int'(sf_start), 0);
        chk(ld_take === 1'b0, "R9 ld_take idle", int'(ld_take), 0);
    endtask

    task automatic t_superframe();  // R2 R3 R4 R5
        for (int f = 0; f < 24; f++) run_frame(f, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_clear();  // R6
        for (int f = 0; f < 24; f++) run_frame(f + 100, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_latch();  // R7 R6
        for (int f = 0; f < 12; f++) run_frame(f + 200, 1'b1, 1'b0, f[0]);
    endtask

    task automatic t_gaps();  // R8
        for (int f = 0; f < 12; f++) run_frame(f + 300, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_midreset();  // R1
        set_inputs(400);
        for (int b = 0; b < 57; b++) tick(1'b1);
        do_reset();
        for (int f = 0; f < 7; f++) run_frame(f + 410, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_superframe();
        t_clear();
        t_latch();
        t_gaps();
        t_midreset();
        finish_run();
    end
endmodule